// File: doc/BRIEF.md
# Bipolar RZ Serial Bit Validator

This block takes the three comparator decisions of a bipolar return-to-zero avionics line (line high, line low, line at null) and turns them into validated 32-bit words. The three level inputs are sampled on a sample tick that runs at ten times the nominal bit rate. The tick comes from the master clock through a prescaler that divides by a fast or a slow ratio, picked by one select input. Each level feeds its own sample shift register. A bit is accepted only when a run of at least three samples of one or zero is followed by at least three null samples. Accepted bits must arrive at a regular spacing, and a full word gap of idle null must pass before a new word is taken.

Accepted bits are shifted into a 32-bit word with the first received bit landing in bit 0. When the 32nd bit is accepted, the block raises a one-cycle end-of-word pulse with the word on `wordOut`. Any timing or level violation during a word raises a one-cycle error pulse, drops the partial word and sends the block back to waiting for a word gap. Line receivers, parity, label filtering and host readout sit outside this block.

Top module: `a429_rx_validator`

## Requirements
- R1: The sample tick occurs once every FAST_DIV (default 10) master clocks while `slowSel` is 0, and once every SLOW_DIV (default 80) master clocks while `slowSel` is 1. A word whose samples are held for the other rate is never delivered.
- R2: While `rstN` is low, `eosPulse`, `errPulse` and `wordOut` are 0 and all sample registers and counters are cleared. After reset a word is accepted only once a full word gap (R7) has passed.
- R3: A word of 32 bits, each a run of at least 3 one or zero samples followed by at least 3 null samples, raises `eosPulse` for exactly one clock. In that cycle `wordOut[n-1]` holds received bit n (1 = one level, 0 = zero level).
- R4: A one or zero run shorter than 3 samples is not a bit.
- R5: Within a word, an accepted bit may follow the previous accepted bit by 8 to 12 sample ticks inclusive. A bit closer than 8 ticks raises `errPulse`.
- R6: Within a word, if 12 sample ticks pass after an accepted bit with no new bit, `errPulse` is raised at the 13th tick.
- R7: After reset, an end-of-word pulse or an error, the block checks the null window once every 10 sample ticks. A check passes when all 10 samples in the window are null. Three passing checks in a row re-arm reception. Any non-null sample restarts the gap count, and words that arrive during the gap are dropped silently.
- R8: During reception, a sample that does not show exactly one of the three levels, or a one sample directly adjacent to a zero sample, raises `errPulse`.
- R9: `eosPulse` and `errPulse` each last one clock, are never high together, and rise only on the clock after a sample tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Synchronous reset, active low |
| slowSel | input | 1 | 0: sample tick = clk/FAST_DIV, 1: sample tick = clk/SLOW_DIV |
| lvlOne | input | 1 | Comparator: line at one level |
| lvlZero | input | 1 | Comparator: line at zero level |
| lvlNull | input | 1 | Comparator: line at null |
| eosPulse | output | 1 | One-cycle end-of-word pulse |
| errPulse | output | 1 | One-cycle violation pulse |
| wordOut | output | 32 | Assembled word, valid while eosPulse is high |

## Verification
The bench keeps the fast divisor at its default of 10 and overrides the slow divisor to 20. This makes the slow-rate path short enough to receive whole words there and to show that a word held for the wrong rate is dropped. Spacing limits, run length and gap count stay at their defaults. The 8- and 12-tick spacing edges, the 13-tick timeout and the gap re-arm are therefore exercised with the values the line actually uses.

// File: rtl/a429_rxv_pkg.sv
`timescale 1ns/1ps
package a429_rxv_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftBit;
    logic bitVal;
  } rxStrobe_t;

  // observations from datapath to control
  typedef struct packed {
    logic tick;
    logic detOne;
    logic detZero;
    logic idleNull;
    logic nullOnly;
    logic illegal;
  } rxStatus_t;

  typedef enum logic {
    ST_GAP  = 1'b0,
    ST_RECV = 1'b1
  } rxState_t;

endpackage

// File: rtl/a429_rxv_datapath.sv
`timescale 1ns/1ps
module a429_rxv_datapath
  import a429_rxv_pkg::*;
#(
  parameter int FAST_DIV  = 10,
  parameter int SLOW_DIV  = 80,
  parameter int SHIFT_LEN = 10,
  parameter int MIN_RUN   = 3,
  parameter int WORD_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 slowSel,
  input  logic                 lvlOne,
  input  logic                 lvlZero,
  input  logic                 lvlNull,
  input  rxStrobe_t            strobe,
  output rxStatus_t            status,
  output logic                 sampleTick,
  output logic [WORD_BITS-1:0] wordOut
);

  localparam int PW        = $clog2(SLOW_DIV + 1);
  localparam int LEVEL_LEN = 2 * MIN_RUN;
  localparam int NUM_LVL   = 2;

  // prescaler
  logic [PW-1:0] preCnt;
  logic [PW-1:0] preLimit;

  always_comb preLimit = slowSel ? PW'(SLOW_DIV - 1) : PW'(FAST_DIV - 1);
  assign sampleTick = (preCnt >= preLimit);

  always_ff @(posedge clk) begin
    if (!rstN)           preCnt <= '0;
    else if (sampleTick) preCnt <= '0;
    else                 preCnt <= preCnt + 1'b1;
  end

  // one/zero sample registers: only the run-plus-null window is kept
  logic                 lvlIn [NUM_LVL];
  logic [LEVEL_LEN-1:0] levelSr [NUM_LVL];
  assign lvlIn[0] = lvlOne;
  assign lvlIn[1] = lvlZero;

  for (genvar gi = 0; gi < NUM_LVL; gi++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (!rstN)           levelSr[gi] <= '0;
      else if (sampleTick) levelSr[gi] <= {levelSr[gi][LEVEL_LEN-2:0], lvlIn[gi]};
    end
  end

  // null sample register spans a full bit time
  logic [SHIFT_LEN-1:0] nullSr;
  always_ff @(posedge clk) begin
    if (!rstN)           nullSr <= '0;
    else if (sampleTick) nullSr <= {nullSr[SHIFT_LEN-2:0], lvlNull};
  end

  logic nullTail;
  logic curOne, curZero, curNull, prvOne, prvZero, legalNow;

  always_comb begin
    nullTail = &nullSr[MIN_RUN-1:0];
    curOne   = levelSr[0][0];
    curZero  = levelSr[1][0];
    curNull  = nullSr[0];
    prvOne   = levelSr[0][1];
    prvZero  = levelSr[1][1];
    legalNow = (curOne & ~curZero & ~curNull) |
               (~curOne & curZero & ~curNull) |
               (~curOne & ~curZero & curNull);

    status.tick     = sampleTick;
    status.detOne   = (&levelSr[0][LEVEL_LEN-1:MIN_RUN]) & nullTail;
    status.detZero  = (&levelSr[1][LEVEL_LEN-1:MIN_RUN]) & nullTail;
    status.idleNull = &nullSr;
    status.nullOnly = curNull & ~curOne & ~curZero;
    status.illegal  = ~legalNow | (curOne & prvZero) | (curZero & prvOne);
  end

  // word assembly: first received bit ends in bit 0
  always_ff @(posedge clk) begin
    if (!rstN)                wordOut <= '0;
    else if (strobe.shiftBit) wordOut <= {strobe.bitVal, wordOut[WORD_BITS-1:1]};
  end

endmodule

// File: rtl/a429_rxv_control.sv
`timescale 1ns/1ps
module a429_rxv_control
  import a429_rxv_pkg::*;
#(
  parameter int SAMPLES_PER_BIT = 10,
  parameter int SPACING_MIN     = 8,
  parameter int SPACING_MAX     = 12,
  parameter int GAP_CHECKS      = 3,
  parameter int WORD_BITS       = 32
) (
  input  logic      clk,
  input  logic      rstN,
  input  rxStatus_t status,
  output rxStrobe_t strobe,
  output logic      eosPulse,
  output logic      errPulse
);

  localparam int BCW = $clog2(WORD_BITS);
  localparam int SW  = $clog2(SPACING_MAX + 2);
  localparam int TW  = $clog2(SAMPLES_PER_BIT);
  localparam int GW  = $clog2(GAP_CHECKS + 1);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(WORD_BITS - 1);
  localparam logic [TW-1:0]  LAST_TMR = TW'(SAMPLES_PER_BIT - 1);
  localparam logic [GW-1:0]  LAST_GAP = GW'(GAP_CHECKS - 1);
  localparam logic [SW-1:0]  SP_MIN   = SW'(SPACING_MIN);
  localparam logic [SW-1:0]  SP_MAX   = SW'(SPACING_MAX);

  rxState_t       state, stateN;
  logic [BCW-1:0] bitCnt, bitCntN;
  logic [SW-1:0]  since, sinceN, spacing;
  logic [TW-1:0]  gapTmr, gapTmrN;
  logic [GW-1:0]  gapCnt, gapCntN;
  logic           eosN, errN, detected, midWord, badSpace, timedOut;

  always_comb begin
    stateN   = state;
    bitCntN  = bitCnt;
    sinceN   = since;
    gapTmrN  = gapTmr;
    gapCntN  = gapCnt;
    eosN     = 1'b0;
    errN     = 1'b0;
    strobe   = '0;
    detected = status.detOne | status.detZero;
    midWord  = (bitCnt != '0);
    spacing  = since + 1'b1;
    badSpace = detected & midWord & ((spacing < SP_MIN) | (spacing > SP_MAX));
    timedOut = ~detected & midWord & (spacing > SP_MAX);

    if (status.tick) begin
      unique case (state)
        ST_GAP: begin
          if (!status.nullOnly) begin
            gapTmrN = '0;
            gapCntN = '0;
          end else if (gapTmr == LAST_TMR) begin
            gapTmrN = '0;
            if (!status.idleNull) begin
              gapCntN = '0;
            end else if (gapCnt == LAST_GAP) begin
              stateN  = ST_RECV;
              gapCntN = '0;
              bitCntN = '0;
              sinceN  = '0;
            end else begin
              gapCntN = gapCnt + 1'b1;
            end
          end else begin
            gapTmrN = gapTmr + 1'b1;
          end
        end
        ST_RECV: begin
          if (status.illegal || badSpace || timedOut) begin
            errN    = 1'b1;
            stateN  = ST_GAP;
            bitCntN = '0;
            gapTmrN = '0;
            gapCntN = '0;
          end else if (detected) begin
            strobe.shiftBit = 1'b1;
            strobe.bitVal   = status.detOne;
            sinceN          = '0;
            if (bitCnt == LAST_BIT) begin
              eosN    = 1'b1;
              stateN  = ST_GAP;
              bitCntN = '0;
              gapTmrN = '0;
              gapCntN = '0;
            end else begin
              bitCntN = bitCnt + 1'b1;
            end
          end else if (midWord) begin
            sinceN = spacing;
          end
        end
        default: stateN = ST_GAP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_GAP;
      bitCnt   <= '0;
      since    <= '0;
      gapTmr   <= '0;
      gapCnt   <= '0;
      eosPulse <= 1'b0;
      errPulse <= 1'b0;
    end else begin
      state    <= stateN;
      bitCnt   <= bitCntN;
      since    <= sinceN;
      gapTmr   <= gapTmrN;
      gapCnt   <= gapCntN;
      eosPulse <= eosN;
      errPulse <= errN;
    end
  end

endmodule

// File: rtl/a429_rx_validator.sv
`timescale 1ns/1ps
module a429_rx_validator
  import a429_rxv_pkg::*;
#(
  parameter int FAST_DIV        = 10,
  parameter int SLOW_DIV        = 80,
  parameter int SAMPLES_PER_BIT = 10,
  parameter int MIN_RUN         = 3,
  parameter int SPACING_MIN     = 8,
  parameter int SPACING_MAX     = 12,
  parameter int GAP_CHECKS      = 3,
  parameter int WORD_BITS       = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 slowSel,
  input  logic                 lvlOne,
  input  logic                 lvlZero,
  input  logic                 lvlNull,
  output logic                 eosPulse,
  output logic                 errPulse,
  output logic [WORD_BITS-1:0] wordOut
);

  rxStrobe_t strobe;
  rxStatus_t status;
  logic      sampleTick;

  a429_rxv_datapath #(
    .FAST_DIV (FAST_DIV),
    .SLOW_DIV (SLOW_DIV),
    .SHIFT_LEN(SAMPLES_PER_BIT),
    .MIN_RUN  (MIN_RUN),
    .WORD_BITS(WORD_BITS)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .slowSel   (slowSel),
    .lvlOne    (lvlOne),
    .lvlZero   (lvlZero),
    .lvlNull   (lvlNull),
    .strobe    (strobe),
    .status    (status),
    .sampleTick(sampleTick),
    .wordOut   (wordOut)
  );

  a429_rxv_control #(
    .SAMPLES_PER_BIT(SAMPLES_PER_BIT),
    .SPACING_MIN    (SPACING_MIN),
    .SPACING_MAX    (SPACING_MAX),
    .GAP_CHECKS     (GAP_CHECKS),
    .WORD_BITS      (WORD_BITS)
  ) ctl_i (
    .clk     (clk),
    .rstN    (rstN),
    .status  (status),
    .strobe  (strobe),
    .eosPulse(eosPulse),
    .errPulse(errPulse)
  );

endmodule

// File: rtl/a429_rxv_checker.sv
`timescale 1ns/1ps
module a429_rxv_checker #(
  parameter int FAST_DIV = 10,
  parameter int SLOW_DIV = 80
) (
  input logic clk,
  input logic rstN,
  input logic slowSel,
  input logic sampleTick,
  input logic eosPulse,
  input logic errPulse
);

  localparam int CW = $clog2(SLOW_DIV + 2);

  logic [CW-1:0] clkSince;
  logic          armed;
  logic          prevSel;
  logic [CW-1:0] expDiv;

  always_comb expDiv = slowSel ? CW'(SLOW_DIV) : CW'(FAST_DIV);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSince <= '0;
      armed    <= 1'b0;
      prevSel  <= 1'b0;
    end else begin
      prevSel <= slowSel;
      if (sampleTick)                 clkSince <= CW'(1);
      else if (clkSince != '1)        clkSince <= clkSince + 1'b1;
      if (slowSel != prevSel)         armed <= 1'b0;
      else if (sampleTick)            armed <= 1'b1;
    end
  end

  assert_tick_period_R1: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && armed && (slowSel == prevSel)) |-> (clkSince == expDiv));

  assert_eos_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    eosPulse |=> !eosPulse);

  assert_err_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> !errPulse);

  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(eosPulse && errPulse));

  assert_eos_after_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
    eosPulse |-> $past(sampleTick));

  assert_err_after_tick_R8: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(sampleTick));

endmodule

bind a429_rx_validator a429_rxv_checker #(
  .FAST_DIV(FAST_DIV),
  .SLOW_DIV(SLOW_DIV)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .slowSel   (slowSel),
  .sampleTick(sampleTick),
  .eosPulse  (eosPulse),
  .errPulse  (errPulse)
);

// File: tb/a429_rx_validator_tb_top.sv
`timescale 1ns/1ps
module a429_rx_validator_tb_top;

  localparam int FAST = 10;
  localparam int SLOW = 20;
  localparam int NVEC = 6;
  // entry: {bit period in samples, word}; bit n of the line sits in word[n-1]
  localparam logic [35:0] VEC [NVEC] = '{
    {4'd10, 32'h0000_0000},
    {4'd10, 32'hFFFF_FFFF},
    {4'd10, 32'hA5C3_0F1E},
    {4'd8,  32'h1234_5678},
    {4'd12, 32'h8000_0001},
    {4'd9,  32'h7E00_81C3}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slowSel = 1'b0;
  logic        lvlOne = 1'b0;
  logic        lvlZero = 1'b0;
  logic        lvlNull = 1'b1;
  logic        eosPulse, errPulse;
  logic [31:0] wordOut;

  int          total = 0;
  int          bad = 0;
  int          eosCnt = 0;
  int          errCnt = 0;
  int          curDiv = FAST;
  logic [31:0] lastWord = '0;

  always #4 clk = ~clk;

  a429_rx_validator #(.FAST_DIV(FAST), .SLOW_DIV(SLOW)) dut_i (
    .clk(clk), .rstN(rstN), .slowSel(slowSel),
    .lvlOne(lvlOne), .lvlZero(lvlZero), .lvlNull(lvlNull),
    .eosPulse(eosPulse), .errPulse(errPulse), .wordOut(wordOut)
  );

  always @(negedge clk) begin
    if (eosPulse) begin
      eosCnt   <= eosCnt + 1;
      lastWord <= wordOut;
    end
    if (errPulse) errCnt <= errCnt + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sample(input logic o, input logic z, input logic n);
    lvlOne  = o;
    lvlZero = z;
    lvlNull = n;
    repeat (curDiv) @(negedge clk);
  endtask

  task automatic nulls(input int cnt);
    for (int i = 0; i < cnt; i++) sample(1'b0, 1'b0, 1'b1);
  endtask

  task automatic bitPulse(input logic v, input int hi, input int lo);
    for (int i = 0; i < hi; i++) sample(v, ~v, 1'b0);
    nulls(lo);
  endtask

  task automatic sendWord(input logic [31:0] w, input int period);
    for (int i = 0; i < 32; i++) bitPulse(w[i], period / 2, period - period / 2);
  endtask

  task automatic goodBits(input int cnt);
    for (int i = 0; i < cnt; i++) bitPulse(i[0], 5, 5);
  endtask

  task automatic expectErr(input string tag, input int e0, input int s0);
    check(errCnt == e0 + 1, tag, 32'(errCnt), 32'(e0 + 1));
    check(eosCnt == s0, tag, 32'(eosCnt), 32'(s0));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int e0, s0;
    @(negedge clk);
    repeat (5) @(negedge clk);
    check(eosPulse == 1'b0, "R2 reset eos", 32'(eosPulse), 32'd0);
    check(errPulse == 1'b0, "R2 reset err", 32'(errPulse), 32'd0);
    check(wordOut == 32'd0, "R2 reset word", wordOut, 32'd0);
    rstN = 1'b1;

    // R2: no full gap after reset, so this word is dropped
    nulls(15);
    sendWord(32'hDEAD_BEEF, 10);
    nulls(45);
    check(eosCnt == 0, "R2 word before gap", 32'(eosCnt), 32'd0);
    check(errCnt == 0, "R2 no err in gap", 32'(errCnt), 32'd0);

    // R3/R5 vector table
    for (int v = 0; v < NVEC; v++) begin
      s0 = eosCnt;
      e0 = errCnt;
      sendWord(VEC[v][31:0], int'(VEC[v][35:32]));
      nulls(45);
      check(eosCnt == s0 + 1, "R3 R5 eos count", 32'(eosCnt), 32'(s0 + 1));
      check(lastWord == VEC[v][31:0], "R3 word", lastWord, VEC[v][31:0]);
      check(errCnt == e0, "R5 no err", 32'(errCnt), 32'(e0));
    end

    // R7: second word follows too soon and is dropped
    s0 = eosCnt;
    sendWord(32'h0F0F_3355, 10);
    nulls(15);
    sendWord(32'hFFFF_0000, 10);
    nulls(45);
    check(eosCnt == s0 + 1, "R7 short gap drop", 32'(eosCnt), 32'(s0 + 1));
    check(lastWord == 32'h0F0F_3355, "R7 kept first word", lastWord, 32'h0F0F_3355);

    // R4: a two-sample pulse is not a bit, word times out
    e0 = errCnt; s0 = eosCnt;
    goodBits(5);
    bitPulse(1'b1, 2, 8);
    nulls(45);
    expectErr("R4 short run", e0, s0);

    // R5: spacing of 6 ticks
    e0 = errCnt; s0 = eosCnt;
    goodBits(4);
    bitPulse(1'b1, 5, 3);
    bitPulse(1'b0, 3, 3);
    nulls(45);
    expectErr("R5 close spacing R9", e0, s0);

    // R6: spacing of 13 ticks
    e0 = errCnt; s0 = eosCnt;
    goodBits(5);
    bitPulse(1'b1, 6, 7);
    bitPulse(1'b1, 6, 7);
    nulls(45);
    expectErr("R6 late bit", e0, s0);

    // R8: two levels in one sample
    e0 = errCnt; s0 = eosCnt;
    goodBits(5);
    sample(1'b1, 1'b1, 1'b0);
    nulls(45);
    expectErr("R8 two levels", e0, s0);

    // R8: one directly into zero
    e0 = errCnt; s0 = eosCnt;
    goodBits(5);
    for (int i = 0; i < 3; i++) sample(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) sample(1'b0, 1'b1, 1'b0);
    nulls(45);
    expectErr("R8 one to zero", e0, s0);

    // R1: slow rate
    slowSel = 1'b1;
    curDiv  = SLOW;
    nulls(45);
    s0 = eosCnt;
    sendWord(32'hC001_5A5A, 10);
    nulls(45);
    check(eosCnt == s0 + 1, "R1 slow eos", 32'(eosCnt), 32'(s0 + 1));
    check(lastWord == 32'hC001_5A5A, "R1 slow word", lastWord, 32'hC001_5A5A);

    // R1: fast-held word while slow selected is never delivered
    s0 = eosCnt;
    curDiv = FAST;
    sendWord(32'h1357_9BDF, 10);
    curDiv = SLOW;
    nulls(45);
    check(eosCnt == s0, "R1 rate mismatch", 32'(eosCnt), 32'(s0));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule